// File: doc/BRIEF.md
# Four-Phase Shared-Bus Nibble Processor

This block is a very small 4-bit processor in which every data movement crosses one 4-bit internal bus. It contains two working registers (A and B), a holding register, a 7-bit program counter, an instruction register, a 4-bit ALU, a 16-entry by 4-bit data RAM, two input ports and two latched output ports. Instructions are 8-bit bytes fetched from an external program ROM, which answers combinationally on the address the block presents.

Each instruction takes exactly four clock cycles. In the first phase the instruction byte is latched and the selected source starts driving the bus. In the second phase the bus is captured into the holding register. In the third phase the holding register drives the bus. In the fourth phase the destination is written and the program counter moves on. ALU results also travel through the holding register, so the ALU always sees the A and B values from before the instruction. A move whose destination is the program counter is a jump. It becomes a no-op when B holds 0xF, and this is the only conditional branch available.

Top module: `nibble_bus_cpu`

## Requirements
- R1: While reset is high at a clock edge, the program counter, A, B, the holding register, the instruction register, both output ports and every RAM word are cleared, and the phase returns to the first phase. After reset, `rom_addr` reads 0 and both output ports read 0.
- R2: Every instruction takes four clocks. `rom_addr` and the output ports change only on the fourth edge of an instruction. With no jump, `rom_addr` rises by one per instruction.
- R3: A byte with bit 7 = 1 is load-immediate: A receives bits 3:0 of the byte, and bits 6:4 are dropped.
- R4: A byte with bits 7:6 = 00 is a move, and bits 5:3 select the source: 000 = A, 001 = B, 011 = RAM word at address B, 100 = input port A, 101 = input port B.
- R5: In a move, bits 2:0 select the destination: 000 = A, 001 = B, 010 = program counter, 011 = RAM word at address B, 100 = output port A, 101 = output port B.
- R6: The data RAM holds 16 words of 4 bits. Register B is always the RAM address, for both reads and writes.
- R7: A byte with bits 7:6 = 01 is an ALU operation. Bit 5 is ignored, bit 4 is the mode, bits 3:0 are the function select, and the result goes to A. With mode = 1 the function is a logic function, selected as follows: 0 ~A, 1 ~(A|B), 2 ~A&B, 3 0, 4 ~(A&B), 5 ~B, 6 A^B, 7 A&~B, 8 ~A|B, 9 ~(A^B), 10 B, 11 A&B, 12 all ones, 13 A|~B, 14 A|B, 15 A.
- R8: With mode = 0, select 1001 gives A+B modulo 16, select 0110 gives A-B modulo 16, and every other select passes A through unchanged.
- R9: A move to the program counter loads the bus value, zero-extended to 7 bits. If B equals 0xF, the move does nothing and the counter advances by one as usual.
- R10: The program counter is 7 bits wide and wraps from 127 to 0.
- R11: Source codes 010, 110 and 111 put 0 on the bus. Destination codes 110 and 111 write nothing, and the program counter still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rom_data | input | 8 | Instruction byte read from the program ROM at `rom_addr` |
| in_a | input | 4 | Input port A |
| in_b | input | 4 | Input port B |
| rom_addr | output | 7 | Program counter, used as the ROM address |
| out_a | output | 4 | Latched output port A |
| out_b | output | 4 | Latched output port B |

## Verification
The fourth-phase edge is where two things meet: the destination write and the program-counter update. A move into the counter turns these into one competing write. The bench provokes this by jumping once with B = 5, which must land on the target, and once with B = 0xF, which must fall through to the next byte. It judges the result purely from `rom_addr`. A second collision is a RAM read and a RAM write at the same B address, which the bench covers by sweeping all 16 addresses. An exhaustive sweep over all 32 ALU functions, every A value and eight B values then checks that the result written back to A was computed from the operands as they stood before the write.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

    localparam int unsigned DATA_W = 4;
    localparam int unsigned INSN_W = 8;
    localparam int unsigned PC_W   = 7;
    localparam int unsigned SEL_W  = 4;

    localparam logic [SEL_W-1:0] ARITH_ADD = 4'b1001;
    localparam logic [SEL_W-1:0] ARITH_SUB = 4'b0110;

    typedef enum logic [1:0] {
        PH_M1 = 2'd0,
        PH_M2 = 2'd1,
        PH_M3 = 2'd2,
        PH_M4 = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        SRC_A   = 3'b000,
        SRC_B   = 3'b001,
        SRC_RAM = 3'b011,
        SRC_INA = 3'b100,
        SRC_INB = 3'b101
    } src_e;

    typedef enum logic [2:0] {
        DST_A    = 3'b000,
        DST_B    = 3'b001,
        DST_PC   = 3'b010,
        DST_RAM  = 3'b011,
        DST_OUTA = 3'b100,
        DST_OUTB = 3'b101
    } dst_e;

    typedef enum logic [1:0] {
        K_MOV = 2'd0,
        K_ALU = 2'd1,
        K_IMM = 2'd2
    } kind_e;

    typedef struct packed {
        logic oe_a;
        logic oe_b;
        logic oe_ram;
        logic oe_ina;
        logic oe_inb;
        logic oe_imm;
        logic oe_alu;
        logic oe_t;
    } drive_t;

    typedef struct packed {
        logic ir;
        logic t;
        logic a;
        logic b;
        logic pc_load;
        logic pc_inc;
        logic ram;
        logic pa;
        logic pb;
    } latch_t;

    typedef struct packed {
        drive_t drv;
        latch_t wr;
    } strobes_t;

    function automatic kind_e classify(input logic [INSN_W-1:0] w);
        if (w[INSN_W-1])      return K_IMM;
        else if (w[INSN_W-2]) return K_ALU;
        else                  return K_MOV;
    endfunction

endpackage

// File: rtl/nbc_phase.sv
module nbc_phase
    import nbc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e ph
);
    phase_e ph_next;

    always_comb begin
        unique case (ph)
            PH_M1:   ph_next = PH_M2;
            PH_M2:   ph_next = PH_M3;
            PH_M3:   ph_next = PH_M4;
            default: ph_next = PH_M1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_M1;
        else     ph <= ph_next;
    end
endmodule

// File: rtl/nbc_decode.sv
module nbc_decode
    import nbc_pkg::*;
(
    input  phase_e              ph,
    input  logic [INSN_W-1:0]   word,
    input  logic                b_full,
    output strobes_t            st
);
    kind_e kind;
    logic  src_win;
    logic  dst_win;
    logic  is_mov;
    logic [2:0] src;
    logic [2:0] dst;

    assign kind    = classify(word);
    assign is_mov  = (kind == K_MOV);
    assign src     = word[5:3];
    assign dst     = word[2:0];
    assign src_win = (ph == PH_M1) || (ph == PH_M2);
    assign dst_win = (ph == PH_M4);

    always_comb begin
        st = '0;
        // Source side: drives the bus during the first two phases
        st.drv.oe_imm = src_win && (kind == K_IMM);
        st.drv.oe_alu = src_win && (kind == K_ALU);
        st.drv.oe_a   = src_win && is_mov && (src == SRC_A);
        st.drv.oe_b   = src_win && is_mov && (src == SRC_B);
        st.drv.oe_ram = src_win && is_mov && (src == SRC_RAM);
        st.drv.oe_ina = src_win && is_mov && (src == SRC_INA);
        st.drv.oe_inb = src_win && is_mov && (src == SRC_INB);
        st.drv.oe_t   = (ph == PH_M3) || (ph == PH_M4);
        // Latch side
        st.wr.ir      = (ph == PH_M1);
        st.wr.t       = (ph == PH_M2);
        st.wr.a       = dst_win && (!is_mov || (dst == DST_A));
        st.wr.b       = dst_win && is_mov && (dst == DST_B);
        st.wr.ram     = dst_win && is_mov && (dst == DST_RAM);
        st.wr.pa      = dst_win && is_mov && (dst == DST_OUTA);
        st.wr.pb      = dst_win && is_mov && (dst == DST_OUTB);
        st.wr.pc_load = dst_win && is_mov && (dst == DST_PC) && !b_full;
        st.wr.pc_inc  = dst_win && !st.wr.pc_load;
    end
endmodule

// File: rtl/nbc_alu.sv
module nbc_alu
    import nbc_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic             mode,
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     y
);
    logic [W-1:0] logic_y;
    logic [W-1:0] arith_y;

    always_comb begin
        unique case (sel)
            4'd0:    logic_y = ~a;
            4'd1:    logic_y = ~(a | b);
            4'd2:    logic_y = ~a & b;
            4'd3:    logic_y = '0;
            4'd4:    logic_y = ~(a & b);
            4'd5:    logic_y = ~b;
            4'd6:    logic_y = a ^ b;
            4'd7:    logic_y = a & ~b;
            4'd8:    logic_y = ~a | b;
            4'd9:    logic_y = ~(a ^ b);
            4'd10:   logic_y = b;
            4'd11:   logic_y = a & b;
            4'd12:   logic_y = '1;
            4'd13:   logic_y = a | ~b;
            4'd14:   logic_y = a | b;
            default: logic_y = a;
        endcase
    end

    always_comb begin
        if (sel == ARITH_ADD)      arith_y = a + b;
        else if (sel == ARITH_SUB) arith_y = a - b;
        else                       arith_y = a;
    end

    assign y = mode ? logic_y : arith_y;
endmodule

// File: rtl/nibble_bus_cpu.sv
module nibble_bus_cpu
    import nbc_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned IW = INSN_W,
    parameter int unsigned PW = PC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rom_data,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    output logic [PW-1:0] rom_addr,
    output logic [DW-1:0] out_a,
    output logic [DW-1:0] out_b
);
    localparam int unsigned RAM_DEPTH = 1 << DW;

    phase_e        phase;
    strobes_t      st;
    logic [IW-1:0] ir;
    logic [IW-1:0] word;
    logic [DW-1:0] ra, rb, rt;
    logic [PW-1:0] pc;
    logic [DW-1:0] ram [RAM_DEPTH];
    logic [DW-1:0] alu_y;
    logic [DW-1:0] bus;
    logic          b_full;

    // The byte being fetched is decoded directly while it is latched
    assign word   = (phase == PH_M1) ? rom_data : ir;
    assign b_full = (rb == '1);

    nbc_phase u_phase (
        .clk (clk),
        .rst (rst),
        .ph  (phase)
    );

    nbc_decode u_dec (
        .ph     (phase),
        .word   (word),
        .b_full (b_full),
        .st     (st)
    );

    nbc_alu #(.W(DW)) u_alu (
        .mode (word[4]),
        .sel  (word[3:0]),
        .a    (ra),
        .b    (rb),
        .y    (alu_y)
    );

    // Shared bus: wired-OR of every gated driver
    assign bus = ({DW{st.drv.oe_a}}   & ra)
               | ({DW{st.drv.oe_b}}   & rb)
               | ({DW{st.drv.oe_ram}} & ram[rb])
               | ({DW{st.drv.oe_ina}} & in_a)
               | ({DW{st.drv.oe_inb}} & in_b)
               | ({DW{st.drv.oe_imm}} & word[DW-1:0])
               | ({DW{st.drv.oe_alu}} & alu_y)
               | ({DW{st.drv.oe_t}}   & rt);

    always_ff @(posedge clk) begin
        if (rst) begin
            ir    <= '0;
            rt    <= '0;
            ra    <= '0;
            rb    <= '0;
            pc    <= '0;
            out_a <= '0;
            out_b <= '0;
        end else begin
            if (st.wr.ir) ir    <= rom_data;
            if (st.wr.t)  rt    <= bus;
            if (st.wr.a)  ra    <= bus;
            if (st.wr.b)  rb    <= bus;
            if (st.wr.pa) out_a <= bus;
            if (st.wr.pb) out_b <= bus;
            if (st.wr.pc_load)     pc <= PW'(bus);
            else if (st.wr.pc_inc) pc <= pc + PW'(1);
        end
    end

    generate
        for (genvar g = 0; g < RAM_DEPTH; g++) begin : g_ram
            always_ff @(posedge clk) begin
                if (rst)
                    ram[g] <= '0;
                else if (st.wr.ram && (rb == DW'(g)))
                    ram[g] <= bus;
            end
        end
    endgenerate

    assign rom_addr = pc;
endmodule

// File: rtl/nbc_cpu_chk.sv
module nbc_cpu_chk
    import nbc_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input phase_e        ph,
    input strobes_t      st,
    input logic [7:0]    ir,
    input logic [3:0]    rb,
    input logic [6:0]    rom_addr,
    input logic [3:0]    out_a,
    input logic [3:0]    out_b
);
    logic [1:0] ph_bits;
    logic       jump_insn;

    assign ph_bits   = ph;
    assign jump_insn = (ir[7:6] == 2'b00) && (ir[2:0] == 3'b010);

    // R2: the four phases follow each other in order
    a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
        (ph_bits != 2'd3) |=> (ph_bits == $past(ph_bits) + 2'd1));
    a_r2_phase_wrap: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_M4) |=> (ph == PH_M1));
    // R2: address and ports only move on the fourth edge
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_M4) |=> $stable(rom_addr));
    a_r2_ports_hold: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_M4) |=> ($stable(out_a) && $stable(out_b)));
    // R4: at most one bus driver at a time
    a_r4_one_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0(st.drv));
    // R3: instruction register only reloads on the first edge
    a_r3_ir_hold: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_M1) |=> $stable(ir));
    // R9: a jump with B full falls through
    a_r9_jump_blocked: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_M4 && jump_insn && rb == 4'hF)
        |=> (rom_addr == $past(rom_addr) + 7'd1));
    // R9: a taken jump lands inside the zero-extended range
    a_r9_jump_taken: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_M4 && jump_insn && rb != 4'hF) |=> (rom_addr[6:4] == 3'b000));
endmodule

bind nibble_bus_cpu nbc_cpu_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ph       (phase),
    .st       (st),
    .ir       (ir),
    .rb       (rb),
    .rom_addr (rom_addr),
    .out_a    (out_a),
    .out_b    (out_b)
);

// File: tb/nibble_bus_cpu_test.sv
module nibble_bus_cpu_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rom_data;
    logic [3:0] in_a = '0;
    logic [3:0] in_b = '0;
    logic [6:0] rom_addr;
    logic [3:0] out_a, out_b;
    logic [7:0] rom [128];

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    assign rom_data = rom[rom_addr];

    nibble_bus_cpu uut (
        .clk      (clk),
        .rst      (rst),
        .rom_data (rom_data),
        .in_a     (in_a),
        .in_b     (in_b),
        .rom_addr (rom_addr),
        .out_a    (out_a),
        .out_b    (out_b)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == 190000) begin
            fails++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 128; i++) rom[i] = 8'h00;
    endtask

    function automatic logic [3:0] model(input logic m, input logic [3:0] s,
                                         input logic [3:0] a, input logic [3:0] b);
        if (m) begin
            case (s)
                4'd0:  return ~a;
                4'd1:  return ~(a | b);
                4'd2:  return ~a & b;
                4'd3:  return 4'h0;
                4'd4:  return ~(a & b);
                4'd5:  return ~b;
                4'd6:  return a ^ b;
                4'd7:  return a & ~b;
                4'd8:  return ~a | b;
                4'd9:  return ~(a ^ b);
                4'd10: return b;
                4'd11: return a & b;
                4'd12: return 4'hF;
                4'd13: return a | ~b;
                4'd14: return a | b;
                default: return a;
            endcase
        end
        if (s == 4'b1001) return 4'((a + b) & 4'hF);
        if (s == 4'b0110) return 4'((a - b) & 4'hF);
        return a;
    endfunction

    initial begin
        clear_rom();
        cyc(2);

        // R1: reset state
        do_reset();
        chk("R1 rom_addr after reset", 8'(rom_addr), 8'h00);
        chk("R1 out_a after reset", 8'(out_a), 8'h0);
        chk("R1 out_b after reset", 8'(out_b), 8'h0);

        // R7 R9 R2: NAND demo loop
        rom[0] = 8'h20; rom[1] = 8'h29; rom[2] = 8'h54; rom[3] = 8'h04;
        rom[4] = 8'h80; rom[5] = 8'h01; rom[6] = 8'h02;
        in_a = 4'hC; in_b = 4'hA;
        do_reset();
        cyc(3);
        chk("R2 address held in phases 1-3", 8'(rom_addr), 8'h00);
        cyc(1);
        chk("R2 address steps after phase 4", 8'(rom_addr), 8'h01);
        cyc(12);
        chk("R7 NAND C,A", 8'(out_a), 8'h7);
        cyc(12);
        chk("R9 jump back to 0", 8'(rom_addr), 8'h00);
        in_a = 4'h3; in_b = 4'h5;
        cyc(16);
        chk("R7 NAND 3,5 second pass", 8'(out_a), 8'hE);

        // R1: reset clears ports that were set
        do_reset();
        chk("R1 out_a cleared", 8'(out_a), 8'h0);

        // R3 R4 R5: immediate, port moves, B as source
        clear_rom();
        rom[0] = 8'hFA; rom[1] = 8'h04;          // A = A (bits 6:4 dropped)
        rom[2] = 8'h25; rom[3] = 8'h2C;          // in_a -> out_b, in_b -> out_a
        rom[4] = 8'h86; rom[5] = 8'h01; rom[6] = 8'h80; rom[7] = 8'h0C; // B=6, A=0, B -> out_a
        in_a = 4'h9; in_b = 4'h4;
        do_reset();
        cyc(8);
        chk("R3 immediate low nibble", 8'(out_a), 8'hA);
        cyc(4);
        chk("R4 R5 in_a to out_b", 8'(out_b), 8'h9);
        cyc(4);
        chk("R4 R5 in_b to out_a", 8'(out_a), 8'h4);
        cyc(16);
        chk("R4 B as source", 8'(out_a), 8'h6);

        // R6: fill all RAM words through B, then read back
        clear_rom();
        for (int k = 0; k < 16; k++) begin
            rom[4*k]   = 8'h80 | 8'(k);
            rom[4*k+1] = 8'h01;
            rom[4*k+2] = 8'h80 | 8'((k * 3 + 1) & 15);
            rom[4*k+3] = 8'h03;
        end
        for (int k = 0; k < 16; k++) begin
            rom[64+3*k]   = 8'h80 | 8'(k);
            rom[64+3*k+1] = 8'h01;
            rom[64+3*k+2] = 8'h1C;
        end
        do_reset();
        cyc(256);
        for (int k = 0; k < 16; k++) begin
            cyc(12);
            chk("R6 RAM readback", 8'(out_a), 8'((k * 3 + 1) & 15));
        end

        // R9: taken jump and blocked jump
        clear_rom();
        rom[0] = 8'h85; rom[1] = 8'h01; rom[2] = 8'h89; rom[3] = 8'h02;
        rom[9] = 8'h8F; rom[10] = 8'h01; rom[11] = 8'h02;
        do_reset();
        cyc(16);
        chk("R9 jump taken with B=5", 8'(rom_addr), 8'h09);
        cyc(12);
        chk("R9 jump blocked with B=F", 8'(rom_addr), 8'h0C);

        // R11: undefined source and destination codes
        clear_rom();
        rom[0] = 8'h87; rom[1] = 8'h34;
        rom[2] = 8'h83; rom[3] = 8'h04;
        rom[4] = 8'h89; rom[5] = 8'h06; rom[6] = 8'h07; rom[7] = 8'h04;
        do_reset();
        cyc(8);
        chk("R11 undefined source gives 0", 8'(out_a), 8'h0);
        cyc(8);
        chk("R11 setup out_a", 8'(out_a), 8'h3);
        cyc(12);
        chk("R11 undefined dest leaves out_a", 8'(out_a), 8'h3);
        chk("R11 undefined dest leaves out_b", 8'(out_b), 8'h0);
        chk("R11 pc still advances", 8'(rom_addr), 8'h07);
        cyc(4);
        chk("R11 A untouched by undefined dest", 8'(out_a), 8'h9);

        // R10: counter wrap over a program of no-ops
        clear_rom();
        do_reset();
        cyc(127 * 4);
        chk("R10 reaches 127", 8'(rom_addr), 8'h7F);
        cyc(4);
        chk("R10 wraps to 0", 8'(rom_addr), 8'h00);

        // R7 R8: sweep of ALU functions, bit 5 set to show it is ignored
        clear_rom();
        rom[0] = 8'h29; rom[1] = 8'h20; rom[3] = 8'h04;
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 16; s++) begin
                rom[2] = {2'b01, 1'(s & 1), 1'(m), 4'(s)};
                for (int a = 0; a < 16; a++) begin
                    for (int k = 0; k < 8; k++) begin
                        in_a = 4'(a);
                        in_b = 4'((k * 7) & 15);
                        do_reset();
                        cyc(16);
                        chk(m ? "R7 logic sweep" : "R8 arith sweep", 8'(out_a),
                            8'(model(1'(m), 4'(s), 4'(a), 4'((k * 7) & 15))));
                    end
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule